// File: doc/BRIEF.md
# Strobed-Address Dynamic Memory Array Model

A synthesizable cycle-level model of a tiny dynamic memory with a 4x4 cell array (16 one-bit words). A memory controller under test uses it as its target. The four-bit word address comes in over two shared address pins, one half at a time.

- A rising row strobe captures the row half and opens that row. The row decoder then drives a one-hot row select, together with the reference row that sits on the far side of the sense line.
- A rising column strobe, while the row is open, captures the column half. It then either puts the chosen cell on the data output or stores the data input into that cell.

Opening a row stands for sensing all of its cells and writing them back. This restarts that row's retention timer. A row that stays closed longer than the retention limit has lost its charge. The next time it opens, its sensed value is all zeros, that value is written back, and a sticky decay flag rises. A controller that skips refresh therefore shows up as lost data. Analog sensing is not modelled. Outputs are registered, so every result appears one clock after the strobe edge that causes it.

Top module: `dram_mux_model`

## Requirements
- R1: After reset every cell holds 0, and `dout_o`, `dout_vld_o`, `row_sel_o`, `ref_sel_o` and `decay_flag_o` are all 0.
- R2: On a clock where `ras_i` is high and was low at the previous clock, `addr_i` is taken as the row. From the next clock until `ras_i` falls, `row_sel_o` has exactly bit `row` set.
- R3: While a row is open, `ref_sel_o` is 2'b10 (reference B) for rows 0 and 1 and 2'b01 (reference A) for rows 2 and 3. It is 2'b00 while no row is open.
- R4: On a clock where `cas_i` rises while a row is open, `addr_i` is taken as the column. From the next clock until either strobe falls, `dout_vld_o` is 1 and `dout_o` is cell[row][column].
- R5: If `we_i` is 1 at the column-strobe rise, `din_i` is stored into cell[row][column], and `dout_o` shows the new value on the next clock.
- R6: Changes of `addr_i` while the strobes stay high do not alter the open row, the open column or the output.
- R7: A row-strobe-only cycle, with no column strobe, leaves all data unchanged and restarts that row's retention time.
- R8: A row that was not open for more than `RET_LIMIT` consecutive clocks reads all zeros when next opened. This also sets `decay_flag_o`, which stays set until reset.
- R9: A row reopened within `RET_LIMIT` clocks keeps its data, and `decay_flag_o` stays low.
- R10: Whenever the row strobe or the column strobe is not active, `dout_vld_o` is 0 and `dout_o` is 0.
- R11: A column-strobe pulse while no row is open is ignored: it stores nothing and does not raise `dout_vld_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Shared row/column address half |
| ras_i | input | 1 | Row strobe, active high |
| cas_i | input | 1 | Column strobe, active high |
| we_i | input | 1 | Write enable, sampled at column-strobe rise |
| din_i | input | 1 | Write data |
| dout_o | output | 1 | Read data, 0 when not valid |
| dout_vld_o | output | 1 | Read data valid |
| row_sel_o | output | 2**ADDR_W | One-hot open-row select |
| ref_sel_o | output | 2 | Reference row select: bit 0 = A, bit 1 = B |
| decay_flag_o | output | 1 | Sticky flag: an expired row was opened |

## Verification
The assertions assume the following about the inputs:
- Strobes are sampled as levels on the clock, with only their rising edges meaningful.
- The column strobe is raised only after the row strobe has been seen high for a clock.
- `we_i` and `din_i` are stable at the column-strobe rise.

The stimulus changes every input on the falling clock edge and always opens a row before pulsing the column strobe. The one exception is the deliberate column-only pulse of R11. Retention is exercised by refreshing three rows in a loop with row-strobe-only cycles while the fourth is left untouched past the limit.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;
    typedef enum logic [1:0] {
        REF_NONE = 2'b00,
        REF_A    = 2'b01,
        REF_B    = 2'b10
    } ref_sel_e;
endpackage

// File: rtl/dram_row_decoder.sv
module dram_row_decoder
    import dram_mux_pkg::*;
#(
    parameter int ADDR_W = 2,
    localparam int ROWS  = 1 << ADDR_W
) (
    input  logic              en_i,
    input  logic [ADDR_W-1:0] row_i,
    output logic [ROWS-1:0]   row_sel_o,
    output ref_sel_e          ref_sel_o
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_sel_o[r] = en_i && (row_i == ADDR_W'(r));
    end

    // Reference row lies on the opposite half of the sense line.
    always_comb begin
        if (!en_i)                  ref_sel_o = REF_NONE;
        else if (row_i[ADDR_W-1])   ref_sel_o = REF_A;
        else                        ref_sel_o = REF_B;
    end
endmodule

// File: rtl/dram_col_mux.sv
module dram_col_mux #(
    parameter int ADDR_W = 2,
    localparam int COLS  = 1 << ADDR_W
) (
    input  logic              en_i,
    input  logic [COLS-1:0]   row_bits_i,
    input  logic [ADDR_W-1:0] col_i,
    output logic              bit_o
);
    assign bit_o = en_i ? row_bits_i[col_i] : 1'b0;
endmodule

// File: rtl/dram_retention.sv
module dram_retention #(
    parameter int ROWS      = 4,
    parameter int RET_LIMIT = 256,
    localparam int CNT_W    = $clog2(RET_LIMIT + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ROWS-1:0] open_i,
    output logic [ROWS-1:0] expired_o
);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(RET_LIMIT + 1);

    logic [CNT_W-1:0] cnt_d [ROWS];
    logic [CNT_W-1:0] cnt_q [ROWS];

    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            if (open_i[r])            cnt_d[r] = '0;
            else if (cnt_q[r] == SAT) cnt_d[r] = SAT;
            else                      cnt_d[r] = cnt_q[r] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        for (int r = 0; r < ROWS; r++) begin
            if (!rst_n) cnt_q[r] <= '0;
            else        cnt_q[r] <= cnt_d[r];
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_exp
        assign expired_o[r] = (cnt_q[r] == SAT);

        AST_OPEN_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
            open_i[r] |=> !expired_o[r]); // R7
    end
endmodule

// File: rtl/dram_mux_model.sv
module dram_mux_model
    import dram_mux_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int RET_LIMIT = 256,
    localparam int ROWS     = 1 << ADDR_W,
    localparam int COLS     = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ras_i,
    input  logic              cas_i,
    input  logic              we_i,
    input  logic              din_i,
    output logic              dout_o,
    output logic              dout_vld_o,
    output logic [ROWS-1:0]   row_sel_o,
    output logic [1:0]        ref_sel_o,
    output logic              decay_flag_o
);
    typedef struct packed {
        logic                       ras_act;
        logic                       cas_act;
        logic                       cas_prev;
        logic [ADDR_W-1:0]          row;
        logic [ADDR_W-1:0]          col;
        logic                       flag;
        logic [ROWS-1:0][COLS-1:0]  cells;
    } state_t;

    state_t          s_d, s_q;
    logic            ras_rise, cas_rise;
    logic [ROWS-1:0] open_rows, expired;
    ref_sel_e        ref_sel;

    assign ras_rise = ras_i && !s_q.ras_act;
    assign cas_rise = cas_i && !s_q.cas_prev && s_q.ras_act;

    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            open_rows[r] = (s_q.ras_act && s_q.row == ADDR_W'(r))
                        || (ras_rise && addr_i == ADDR_W'(r));
        end
    end

    dram_retention #(.ROWS(ROWS), .RET_LIMIT(RET_LIMIT)) u_ret (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_i   (open_rows),
        .expired_o(expired)
    );

    always_comb begin
        s_d          = s_q;
        s_d.cas_prev = cas_i;
        if (!ras_i) begin
            s_d.ras_act = 1'b0;
            s_d.cas_act = 1'b0;
        end else if (ras_rise) begin
            s_d.ras_act = 1'b1;
            s_d.row     = addr_i;
            // Sensing an expired row writes back the decayed (zero) value.
            if (expired[addr_i]) begin
                s_d.cells[addr_i] = '0;
                s_d.flag          = 1'b1;
            end
        end else if (!cas_i) begin
            s_d.cas_act = 1'b0;
        end else if (cas_rise) begin
            s_d.cas_act = 1'b1;
            s_d.col     = addr_i;
            if (we_i) s_d.cells[s_q.row][addr_i] = din_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    dram_row_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .en_i     (s_q.ras_act),
        .row_i    (s_q.row),
        .row_sel_o(row_sel_o),
        .ref_sel_o(ref_sel)
    );

    dram_col_mux #(.ADDR_W(ADDR_W)) u_mux (
        .en_i      (s_q.ras_act && s_q.cas_act),
        .row_bits_i(s_q.cells[s_q.row]),
        .col_i     (s_q.col),
        .bit_o     (dout_o)
    );

    assign ref_sel_o    = ref_sel;
    assign dout_vld_o   = s_q.ras_act && s_q.cas_act;
    assign decay_flag_o = s_q.flag;

    AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ras_act |-> $countones(row_sel_o) == 1); // R2
    AST_REF_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (|row_sel_o[ROWS/2-1:0]) |-> ref_sel_o == REF_B); // R3
    AST_REF_HIGH_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (|row_sel_o[ROWS-1:ROWS/2]) |-> ref_sel_o == REF_A); // R3
    AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ras_act && ras_i) |=> $stable(row_sel_o)); // R6
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_rise && ras_i && we_i) |=> (dout_vld_o && dout_o == $past(din_i))); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        decay_flag_o |=> decay_flag_o); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.ras_act |-> (!dout_vld_o && !dout_o && row_sel_o == '0)); // R10
endmodule

// File: tb/tb_dram_mux_model.sv
module tb_dram_mux_model;
    localparam int ADDR_W = 2;
    localparam int N      = 1 << ADDR_W;
    localparam int LIMIT  = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic ras = 0, cas = 0, we = 0, din = 0;
    logic dout, vld, flag;
    logic [N-1:0] row_sel;
    logic [1:0] ref_sel;

    int checks = 0, errors = 0;
    bit done = 0;
    logic shadow [N][N];

    always #10 clk = ~clk;

    dram_mux_model #(.ADDR_W(ADDR_W), .RET_LIMIT(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .ras_i(ras), .cas_i(cas),
        .we_i(we), .din_i(din), .dout_o(dout), .dout_vld_o(vld),
        .row_sel_o(row_sel), .ref_sel_o(ref_sel), .decay_flag_o(flag));

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic pat(int r, int c, int k);
        return ((r * 4 + c + k) % 3) != 0;
    endfunction

    function automatic logic [1:0] ref_exp(int r);
        return (r < N / 2) ? 2'b10 : 2'b01;
    endfunction

    // Full read or write access; outputs sampled on the falling edge.
    task automatic access(int r, int c, bit wr, logic d);
        @(negedge clk); ras = 1; addr = ADDR_W'(r);
        @(negedge clk);
        check("R2 row select", 32'(row_sel), 32'(1 << r));
        check("R3 reference", 32'(ref_sel), 32'(ref_exp(r)));
        check("R10 no data before column", {31'd0, vld}, 0);
        cas = 1; addr = ADDR_W'(c); we = wr; din = d;
        @(negedge clk);
        if (wr) shadow[r][c] = d;
        check("R4 valid", {31'd0, vld}, 1);
        check(wr ? "R5 written data" : "R4 read data", {31'd0, dout}, 32'(shadow[r][c]));
        cas = 0; ras = 0; we = 0;
    endtask

    task automatic ras_only(int r);
        @(negedge clk); ras = 1; addr = ADDR_W'(r);
        @(negedge clk);
        check("R10 valid low on row-only", {31'd0, vld}, 0);
        ras = 0;
    endtask

    initial begin
        for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) shadow[r][c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 dout", {31'd0, dout}, 0);
        check("R1 valid", {31'd0, vld}, 0);
        check("R1 row select", 32'(row_sel), 0);
        check("R1 reference", 32'(ref_sel), 0);
        check("R1 flag", {31'd0, flag}, 0);
        access(2, 1, 0, 1'b0);

        // Sweep two patterns over all cells: write all, then read all.
        for (int k = 0; k < 2; k++) begin
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++) access(r, c, 1, pat(r, c, k));
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++) access(r, c, 0, 1'b0);
        end

        // R6: address wiggles while strobes held
        @(negedge clk); ras = 1; addr = 2'd1;
        @(negedge clk); cas = 1; addr = 2'd2;
        @(negedge clk); addr = 2'd3;
        @(negedge clk); addr = 2'd0;
        @(negedge clk);
        check("R6 row held", 32'(row_sel), 32'(1 << 1));
        check("R6 data held", {31'd0, dout}, 32'(shadow[1][2]));
        cas = 0;
        @(negedge clk);
        check("R10 valid drops with column strobe", {31'd0, vld}, 0);
        check("R10 dout zero", {31'd0, dout}, 0);
        ras = 0;

        // R11: column pulse with no open row
        @(negedge clk); cas = 1; we = 1; din = ~shadow[0][0]; addr = 2'd0;
        @(negedge clk);
        check("R11 no valid", {31'd0, vld}, 0);
        cas = 0; we = 0;
        @(negedge clk);
        access(0, 0, 0, 1'b0);

        // R7/R9/R8: refresh rows 0..2 by row-only cycles, starve row 3.
        for (int i = 0; i < 70; i++)
            for (int r = 0; r < N - 1; r++) ras_only(r);
        check("R9 flag still low", {31'd0, flag}, 0);
        for (int r = 0; r < N - 1; r++)
            for (int c = 0; c < N; c++) access(r, c, 0, 1'b0); // R7 data intact
        check("R9 flag low after refreshed reads", {31'd0, flag}, 0);
        for (int c = 0; c < N; c++) shadow[N-1][c] = 0;
        access(N - 1, 0, 0, 1'b0);
        @(negedge clk);
        check("R8 decay flag set", {31'd0, flag}, 1);
        for (int c = 1; c < N; c++) access(N - 1, c, 0, 1'b0); // R8 zeros
        access(0, 1, 0, 1'b0);
        check("R8 flag sticky", {31'd0, flag}, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule